// File: doc/BRIEF.md
# Two-Phase Shared-Memory Processor Controller

This block is the control unit of a small non-pipelined processor whose instructions and data live in one single-ported memory. A phase register marks each cycle as either an instruction-fetch cycle or an execute cycle. From the phase, a three-bit instruction class and the datapath's zero flag, it drives the PC enable, the IR enable, the IR source select (memory word or nop), the memory address select (PC or ALU result), the memory write enable and the register-file write enable.

In the baseline mode every instruction takes exactly two cycles, fetch then execute, with no overlap. In the overlapped mode the next instruction is fetched during the execute cycle of the current one. Because the single port cannot serve a data access and a fetch in the same cycle, a load or store makes the IR take a nop and holds the PC so that the fetch is retried. There is no branch delay slot, so a taken branch or jump also makes the IR take a nop in place of the word fetched on the wrong path. The mode input is treated as static and may only change while reset is held.

Top module: `shmem_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, phase is 0 (fetch).
- R2: With overlap_mode low, phase inverts on every clock edge.
- R3: With overlap_mode high, phase is 1 (execute) on every cycle after the first post-reset cycle.
- R4: When phase is 0: ir_en=1, ir_nop=0, addr_sel=0 (PC), pc_en=0, mem_we=0, reg_we=0, whatever the opcode and zero flag.
- R5: Opcode classes: 0 ALU, 1 load, 2 store, 3 branch-if-zero, 4 jump, 5 to 7 no operation. When phase is 1, addr_sel=1 exactly for load and store, mem_we=1 exactly for store, reg_we=1 exactly for ALU and load, in both modes.
- R6: When phase is 1 with overlap_mode low: pc_en=1, ir_en=0, ir_nop=0.
- R7: When phase is 1 with overlap_mode high and a load or store: ir_en=1, ir_nop=1, pc_en=0.
- R8: When phase is 1 with overlap_mode high and a taken transfer (jump, or branch-if-zero with alu_zero=1): pc_en=1, ir_en=1, ir_nop=1.
- R9: When phase is 1 with overlap_mode high and any other opcode, including an untaken branch (alu_zero=0): pc_en=1, ir_en=1, ir_nop=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| overlap_mode | input | 1 | 1 selects overlapped fetch, 0 the two-cycle baseline |
| opcode | input | OPW | Instruction class of the word held in the IR |
| alu_zero | input | 1 | Zero flag from the ALU, decides branch-if-zero |
| phase | output | 1 | 0 fetch cycle, 1 execute cycle |
| pc_en | output | 1 | PC load enable |
| ir_en | output | 1 | IR load enable |
| ir_nop | output | 1 | IR source: 1 nop, 0 memory read data |
| addr_sel | output | 1 | Memory address source: 1 ALU result, 0 PC |
| mem_we | output | 1 | Memory write enable |
| reg_we | output | 1 | Register file write enable |

## Verification
The only state is the phase bit, so a wrong phase shows at once as the whole output pattern of the other phase: in baseline mode an IR load in an execute cycle or a PC update in a fetch cycle, visible in the same cycle the phase goes wrong. In overlapped mode a phase stuck at fetch would show as a missing PC advance and missing writes on the very next cycle. The bench sweeps every opcode and zero-flag value through both phases of both modes and compares each output in every cycle.

// File: rtl/shmem_ctrl.sv
module shmem_ctrl #(
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           overlap_mode,
  input  logic [OPW-1:0] opcode,
  input  logic           alu_zero,
  output logic           phase,
  output logic           pc_en,
  output logic           ir_en,
  output logic           ir_nop,
  output logic           addr_sel,
  output logic           mem_we,
  output logic           reg_we
);
  localparam logic [OPW-1:0] OP_ALU  = OPW'(0);
  localparam logic [OPW-1:0] OP_LD   = OPW'(1);
  localparam logic [OPW-1:0] OP_ST   = OPW'(2);
  localparam logic [OPW-1:0] OP_BEQZ = OPW'(3);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(4);

  logic is_alu, is_ld, is_st, is_mem, take;

  assign is_alu = (opcode == OP_ALU);
  assign is_ld  = (opcode == OP_LD);
  assign is_st  = (opcode == OP_ST);
  assign is_mem = is_ld | is_st;
  assign take   = (opcode == OP_JMP) | ((opcode == OP_BEQZ) & alu_zero);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= 1'b0;
    else        phase <= overlap_mode ? 1'b1 : ~phase;

  assign pc_en    = phase & ~(overlap_mode & is_mem);
  assign ir_en    = ~phase | overlap_mode;
  assign ir_nop   = phase & overlap_mode & (is_mem | take);
  assign addr_sel = phase & is_mem;
  assign mem_we   = phase & is_st;
  assign reg_we   = phase & (is_alu | is_ld);

  AST_BASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap_mode |=> (phase != $past(phase))); // R2
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && !ir_nop) |-> !addr_sel); // R4
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (addr_sel && !reg_we)); // R5
  AST_BASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap_mode |-> !(pc_en && ir_en)); // R6
  AST_PORT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap_mode && addr_sel) |-> (!pc_en && ir_en && ir_nop)); // R7
  AST_OVL_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap_mode && phase) |=> phase); // R3
endmodule

// File: tb/shmem_ctrl_bench.sv
`timescale 1ns/1ps
module shmem_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic overlap_mode = 1'b0;
  logic [2:0] opcode = 3'd0;
  logic alu_zero = 1'b0;
  logic phase, pc_en, ir_en, ir_nop, addr_sel, mem_we, reg_we;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic exp_ph;

  always #2.5 clk = ~clk;

  shmem_ctrl #(.OPW(3)) u_shmem_ctrl (
    .clk(clk), .rst_n(rst_n), .overlap_mode(overlap_mode), .opcode(opcode),
    .alu_zero(alu_zero), .phase(phase), .pc_en(pc_en), .ir_en(ir_en),
    .ir_nop(ir_nop), .addr_sel(addr_sel), .mem_we(mem_we), .reg_we(reg_we)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s m=%0d op=%0d z=%0d ph=%0d: got %0b exp %0b",
               tag, overlap_mode, opcode, alu_zero, exp_ph, act, exp);
    end
  endtask

  task automatic check_all();
    logic e_pc, e_ir, e_nop, e_adr, e_mw, e_rw, mem, tk;
    mem = (opcode == 3'd1) || (opcode == 3'd2);
    tk  = (opcode == 3'd4) || (opcode == 3'd3 && alu_zero);
    if (!exp_ph) begin
      {e_pc, e_ir, e_nop, e_adr, e_mw, e_rw} = 6'b010000;
    end else begin
      e_adr = mem;
      e_mw  = (opcode == 3'd2);
      e_rw  = (opcode == 3'd0) || (opcode == 3'd1);
      if (!overlap_mode) begin
        e_pc = 1'b1; e_ir = 1'b0; e_nop = 1'b0;
      end else if (mem) begin
        e_pc = 1'b0; e_ir = 1'b1; e_nop = 1'b1;
      end else if (tk) begin
        e_pc = 1'b1; e_ir = 1'b1; e_nop = 1'b1;
      end else begin
        e_pc = 1'b1; e_ir = 1'b1; e_nop = 1'b0;
      end
    end
    chk(overlap_mode ? "R3 phase" : "R2 phase", phase, exp_ph);
    chk(!exp_ph ? "R4 pc_en" : (overlap_mode ? (mem ? "R7 pc_en" : "R8/R9 pc_en") : "R6 pc_en"), pc_en, e_pc);
    chk(!exp_ph ? "R4 ir_en" : (overlap_mode ? "R7/R8/R9 ir_en" : "R6 ir_en"), ir_en, e_ir);
    chk(!exp_ph ? "R4 ir_nop" : (overlap_mode ? (tk ? "R8 ir_nop" : "R7/R9 ir_nop") : "R6 ir_nop"), ir_nop, e_nop);
    chk(!exp_ph ? "R4 addr_sel" : "R5 addr_sel", addr_sel, e_adr);
    chk(!exp_ph ? "R4 mem_we" : "R5 mem_we", mem_we, e_mw);
    chk(!exp_ph ? "R4 reg_we" : "R5 reg_we", reg_we, e_rw);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      rst_n = 1'b0;
      overlap_mode = m[0];
      exp_ph = 1'b0;
      repeat (2) @(negedge clk);
      #1 chk("R1 reset phase", phase, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int op = 0; op < 8; op++) begin
        for (int z = 0; z < 2; z++) begin
          for (int c = 0; c < 2; c++) begin
            opcode = op[2:0];
            alu_zero = z[0];
            #1 check_all();
            @(posedge clk);
            exp_ph = overlap_mode ? 1'b1 : ~exp_ph;
            @(negedge clk);
          end
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule